// File: doc/BRIEF.md
# Tuning Word History Averager

This block keeps a running history of the frequency tuning words that a digital PLL loop filter produces. While the loop is locked in closed loop, each valid tuning word is added into a wide accumulator and counted. Millisecond ticks measure out a programmable interval. When an interval ends, the accumulated sum is divided by the sample count and the quotient becomes the new holdover tuning word. The mode controller can then select that word when it has to stop following the reference.

If the loop leaves closed loop partway through an interval, the partial interval is discarded. The output keeps the last completed average, so a clean holdover value is always available. A flag shows whether any average has been produced since reset. A one-cycle pulse marks each new value.

The division is sequential, one quotient bit per clock. A new value therefore appears a fixed number of cycles after the tick that closes the interval. At millisecond interval rates this latency is negligible.

Top module: `twHistory`

## Requirements
- R1: After reset, avgOut is 0, histValid is 0 and avgUpdate is 0.
- R2: A tuning word is accumulated only in a cycle where twValid and closedLoop are both 1. The written average is floor(sum / count) over the words accumulated in the interval, truncated to WORD_W bits.
- R3: An interval ends on the clock edge of the intervalMs-th msTick counted in closed loop since closed loop began or since the previous interval end. An intervalMs value of 0 behaves as 1. A word presented on the ending tick's cycle belongs to the ending interval.
- R4: When closedLoop is 0, the partial sum, the sample count and the tick count are cleared. The output and histValid keep their last values.
- R5: histValid stays 0 until the first average is written. It becomes 1 in the same cycle as that first avgUpdate and stays 1 until reset.
- R6: avgUpdate is high for exactly one cycle, WORD_W+CNT_W+1 clock edges after the edge of the interval-ending tick. avgOut changes only at the edge that raises avgUpdate.
- R7: An interval that ends with zero accumulated samples writes nothing. avgOut and histValid are unchanged and no avgUpdate occurs.
- R8: If an interval ends while the previous division is still running (including its write cycle), that interval produces no update. Accumulation for the next interval still restarts from zero.
- R9: The sample count of an interval saturates at 2^CNT_W-1. Further words in that interval are not accumulated.
- R10: msTick pulses while closedLoop is 0 are ignored. They do not advance the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| twIn | input | WORD_W | Tuning word from the loop filter |
| twValid | input | 1 | twIn carries a new sample this cycle |
| closedLoop | input | 1 | PLL is locked in closed loop |
| msTick | input | 1 | One-cycle pulse per millisecond |
| intervalMs | input | INTV_W | Averaging interval in milliseconds (0 means 1) |
| avgOut | output | WORD_W | Latest completed average tuning word |
| histValid | output | 1 | At least one average has been written since reset |
| avgUpdate | output | 1 | One-cycle pulse when avgOut takes a new value |

## Verification
The bench builds the block with WORD_W=16, CNT_W=6 and INTV_W=4. The division then takes 22 steps and the write latency is 23 edges. A single interval driven with a word on every cycle goes past the 63-sample saturation point. Ticks can also be spaced closer together than the division latency, which exercises the case where a completed interval is dropped while a division is busy. A 4-bit interval field makes the zero-means-one case and multi-tick intervals take only a few hundred cycles each.

// File: rtl/twHistPkg.sv
package twHistPkg;

  // Strobes from the sequencing control to the accumulate/divide datapath
  typedef struct packed {
    logic clearAcc;  // restart accumulation (open loop or interval end)
    logic loadDiv;   // capture sum and count into the divider
    logic stepDiv;   // perform one restoring-division step
    logic writeOut;  // copy the finished quotient to the output register
  } histStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIV   = 2'd1,
    ST_WRITE = 2'd2
  } divState_t;

endpackage

// File: rtl/twHistCtrl.sv
module twHistCtrl
  import twHistPkg::*;
#(
  parameter int INTV_W = 24,
  parameter int SUM_W  = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              closedLoop,
  input  logic              msTick,
  input  logic [INTV_W-1:0] intervalMs,
  input  logic              sampleAvail,
  output histStrobes_t      strobes
);

  localparam int STEP_W = $clog2(SUM_W + 1);

  logic [INTV_W-1:0] msCount;
  logic [INTV_W:0]   msNext;
  logic [INTV_W:0]   effLen;
  logic              intervalEnd;
  logic [STEP_W-1:0] stepCnt;
  divState_t         state;

  assign msNext = {1'b0, msCount} + (INTV_W+1)'(1);
  assign effLen = (intervalMs == '0) ? (INTV_W+1)'(1) : {1'b0, intervalMs};

  // Ticks count only in closed loop; the interval closes on the tick that reaches the length
  assign intervalEnd = closedLoop & msTick & (msNext >= effLen);

  always_comb begin
    strobes.clearAcc = ~closedLoop | intervalEnd;
    strobes.loadDiv  = intervalEnd & (state == ST_IDLE) & sampleAvail;
    strobes.stepDiv  = (state == ST_DIV);
    strobes.writeOut = (state == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msCount <= '0;
    end else if (!closedLoop || intervalEnd) begin
      msCount <= '0;
    end else if (msTick) begin
      msCount <= msNext[INTV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobes.loadDiv) begin
            state   <= ST_DIV;
            stepCnt <= STEP_W'(SUM_W);
          end
        end
        ST_DIV: begin
          stepCnt <= stepCnt - STEP_W'(1);
          if (stepCnt == STEP_W'(1)) begin
            state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/twHistPath.sv
module twHistPath
  import twHistPkg::*;
#(
  parameter int WORD_W = 48,
  parameter int CNT_W  = 32,
  parameter int SUM_W  = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] twIn,
  input  logic              twValid,
  input  logic              closedLoop,
  input  histStrobes_t      strobes,
  output logic              sampleAvail,
  output logic [WORD_W-1:0] avgOut,
  output logic              histValid,
  output logic              avgUpdate
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SUM_W-1:0] sumAcc;
  logic [SUM_W-1:0] sumNext;
  logic [CNT_W-1:0] cntAcc;
  logic [CNT_W-1:0] cntNext;
  logic             addOk;

  // Divider registers: dividend shifts into the quotient in place
  logic [SUM_W-1:0] dvd;
  logic [CNT_W-1:0] dvs;
  logic [CNT_W-1:0] rem;
  logic [CNT_W:0]   trial;
  logic [CNT_W:0]   diff;

  assign addOk       = closedLoop & twValid & (cntAcc != CNT_MAX);
  assign sumNext     = sumAcc + (addOk ? SUM_W'(twIn) : '0);
  assign cntNext     = cntAcc + CNT_W'(addOk);
  assign sampleAvail = (cntNext != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sumAcc <= '0;
      cntAcc <= '0;
    end else if (strobes.clearAcc) begin
      sumAcc <= '0;
      cntAcc <= '0;
    end else if (addOk) begin
      sumAcc <= sumNext;
      cntAcc <= cntNext;
    end
  end

  assign trial = {rem, dvd[SUM_W-1]};
  assign diff  = trial - {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd <= '0;
      dvs <= '0;
      rem <= '0;
    end else if (strobes.loadDiv) begin
      dvd <= sumNext;
      dvs <= cntNext;
      rem <= '0;
    end else if (strobes.stepDiv) begin
      if (!diff[CNT_W]) begin
        rem <= diff[CNT_W-1:0];
        dvd <= {dvd[SUM_W-2:0], 1'b1};
      end else begin
        rem <= trial[CNT_W-1:0];
        dvd <= {dvd[SUM_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avgOut    <= '0;
      histValid <= 1'b0;
      avgUpdate <= 1'b0;
    end else begin
      avgUpdate <= strobes.writeOut;
      if (strobes.writeOut) begin
        avgOut    <= dvd[WORD_W-1:0];
        histValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/twHistory.sv
module twHistory
  import twHistPkg::*;
#(
  parameter int WORD_W = 48,
  parameter int CNT_W  = 32,
  parameter int INTV_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] twIn,
  input  logic              twValid,
  input  logic              closedLoop,
  input  logic              msTick,
  input  logic [INTV_W-1:0] intervalMs,
  output logic [WORD_W-1:0] avgOut,
  output logic              histValid,
  output logic              avgUpdate
);

  localparam int SUM_W = WORD_W + CNT_W;

  histStrobes_t strobes;
  logic         sampleAvail;

  twHistCtrl #(
    .INTV_W(INTV_W),
    .SUM_W (SUM_W)
  ) ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .closedLoop (closedLoop),
    .msTick     (msTick),
    .intervalMs (intervalMs),
    .sampleAvail(sampleAvail),
    .strobes    (strobes)
  );

  twHistPath #(
    .WORD_W(WORD_W),
    .CNT_W (CNT_W),
    .SUM_W (SUM_W)
  ) path (
    .clk        (clk),
    .rst_n      (rst_n),
    .twIn       (twIn),
    .twValid    (twValid),
    .closedLoop (closedLoop),
    .strobes    (strobes),
    .sampleAvail(sampleAvail),
    .avgOut     (avgOut),
    .histValid  (histValid),
    .avgUpdate  (avgUpdate)
  );

endmodule

// File: rtl/twHistoryChk.sv
module twHistoryChk #(
  parameter int WORD_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] avgOut,
  input logic              histValid,
  input logic              avgUpdate
);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    avgUpdate |=> !avgUpdate);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !avgUpdate |-> $stable(avgOut));

  assert_hist_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    histValid |=> histValid);

  assert_hist_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(histValid) |-> avgUpdate);

  assert_update_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    avgUpdate |-> histValid);

endmodule

bind twHistory twHistoryChk #(.WORD_W(WORD_W)) chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .avgOut   (avgOut),
  .histValid(histValid),
  .avgUpdate(avgUpdate)
);

// File: tb/twHistory_test.sv
module twHistory_test;

  localparam int WW   = 16;
  localparam int CW   = 6;
  localparam int IW   = 4;
  localparam int LAT  = WW + CW + 1;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WW-1:0] twIn = '0;
  logic          twValid = 1'b0;
  logic          closedLoop = 1'b0;
  logic          msTick = 1'b0;
  logic [IW-1:0] intervalMs = '0;
  logic [WW-1:0] avgOut;
  logic          histValid;
  logic          avgUpdate;

  int checks = 0;
  int fails = 0;
  int updCount = 0;
  int wordIdx = 0;
  string phase = "R1";

  // Behavioural reference state
  longint mSum = 0;
  int     mCnt = 0;
  int     mMs = 0;
  int     mCd = 0;
  longint mPend = 0;
  longint mOut = 0;
  bit     mHv = 0;
  bit     mUpd = 0;

  always #5 clk = ~clk;

  twHistory #(.WORD_W(WW), .CNT_W(CW), .INTV_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .twIn(twIn), .twValid(twValid),
    .closedLoop(closedLoop), .msTick(msTick), .intervalMs(intervalMs),
    .avgOut(avgOut), .histValid(histValid), .avgUpdate(avgUpdate)
  );

  always @(posedge clk) begin : refModel
    int len;
    bit busy;
    if (!rst_n) begin
      mSum = 0; mCnt = 0; mMs = 0; mCd = 0; mPend = 0;
      mOut = 0; mHv = 0; mUpd = 0;
    end else begin
      busy = (mCd > 0);
      mUpd = 0;
      if (mCd > 0) begin
        mCd--;
        if (mCd == 0) begin
          mOut = mPend; mHv = 1; mUpd = 1;
        end
      end
      if (!closedLoop) begin
        mSum = 0; mCnt = 0; mMs = 0;
      end else begin
        if (twValid && mCnt < CMAX) begin
          mSum += longint'(twIn);
          mCnt++;
        end
        if (msTick) begin
          mMs++;
          len = (intervalMs == 0) ? 1 : int'(intervalMs);
          if (mMs >= len) begin
            if (!busy && mCnt > 0) begin
              mPend = mSum / mCnt;
              mCd = LAT;
            end
            mSum = 0; mCnt = 0; mMs = 0;
          end
        end
      end
    end
  end

  function automatic logic [WW-1:0] wordAt(int k);
    return WW'(k * 32'h2F1B + 32'h0123);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(64'(avgOut) == mOut, phase, "avgOut", longint'(avgOut), mOut);
    check(histValid == mHv, "R5", "histValid", longint'(histValid), longint'(mHv));
    check(avgUpdate == mUpd, "R6", "avgUpdate", longint'(avgUpdate), longint'(mUpd));
  endtask

  task automatic step(bit v, bit cl, bit tk);
    @(negedge clk);
    compareAll();
    if (avgUpdate) updCount++;
    twValid = v; closedLoop = cl; msTick = tk;
    twIn = wordAt(wordIdx);
    wordIdx++;
  endtask

  task automatic runTicks(int nT, int gap, int vPer, bit cl);
    for (int t = 0; t < nT; t++) begin
      for (int c = 0; c < gap; c++) begin
        step((vPer > 0) && (c % vPer == 0), cl, c == gap - 1);
      end
    end
  endtask

  task automatic flush();
    repeat (LAT + 6) step(1'b0, closedLoop, 1'b0);
    repeat (2) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 to R10 watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin : mainSeq
    logic [WW-1:0] saved;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(avgOut == '0, "R1", "avgOut in reset", longint'(avgOut), 0);
      check(histValid == 1'b0, "R1", "histValid in reset", longint'(histValid), 0);
      check(avgUpdate == 1'b0, "R1", "avgUpdate in reset", longint'(avgUpdate), 0);
    end
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0);
    check(histValid == 1'b0, "R5", "histValid before first average", longint'(histValid), 0);

    // R2 and R3: sparse samples, three-tick interval
    phase = "R2"; intervalMs = 4'd3; updCount = 0;
    runTicks(7, 40, 4, 1'b1); flush();
    check(updCount == 2, "R3", "updates for 7 ticks at length 3", updCount, 2);
    check(64'(avgOut) == mOut, "R2", "average value", longint'(avgOut), mOut);
    check(histValid == 1'b1, "R5", "histValid after first average", longint'(histValid), 1);

    // R3: zero length behaves as one tick
    phase = "R3"; intervalMs = 4'd0; updCount = 0;
    runTicks(3, 40, 2, 1'b1); flush();
    check(updCount == 3, "R3", "updates at length 0", updCount, 3);

    // R4: leaving closed loop mid-interval discards the partial interval
    phase = "R4"; intervalMs = 4'd4; updCount = 0; saved = avgOut;
    runTicks(2, 40, 3, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, i == 5);
    check(avgOut == saved, "R4", "avgOut held after open loop", longint'(avgOut), longint'(saved));
    check(updCount == 0, "R4", "no update from discarded interval", updCount, 0);
    runTicks(4, 40, 3, 1'b1); flush();
    check(updCount == 1, "R4", "fresh interval after return", updCount, 1);

    // R7: an interval with no samples writes nothing
    phase = "R7"; intervalMs = 4'd2; updCount = 0; saved = avgOut;
    runTicks(3, 40, 0, 1'b1); flush();
    check(updCount == 0, "R7", "no update for empty interval", updCount, 0);
    check(avgOut == saved, "R7", "avgOut kept", longint'(avgOut), longint'(saved));

    // R8: interval ends during a running division are dropped
    phase = "R8"; intervalMs = 4'd1; updCount = 0;
    runTicks(6, 10, 1, 1'b1); flush();
    check(updCount == 2, "R8", "updates with ticks closer than latency", updCount, 2);

    // R9: sample count saturation
    phase = "R9"; intervalMs = 4'd3; updCount = 0;
    runTicks(3, 40, 1, 1'b1); flush();
    check(updCount == 1, "R9", "one update for saturated interval", updCount, 1);
    check(64'(avgOut) == mOut, "R9", "average of first samples", longint'(avgOut), mOut);

    // R10: ticks in open loop do not advance the interval
    phase = "R10"; intervalMs = 4'd2; updCount = 0; saved = avgOut;
    runTicks(5, 40, 1, 1'b0);
    check(updCount == 0, "R10", "no update from open-loop ticks", updCount, 0);
    check(avgOut == saved, "R10", "avgOut kept in open loop", longint'(avgOut), longint'(saved));
    runTicks(1, 40, 2, 1'b1);
    repeat (LAT + 6) step(1'b0, 1'b1, 1'b0);
    check(updCount == 0, "R10", "one closed tick does not end length 2", updCount, 0);
    runTicks(1, 40, 2, 1'b1); flush();
    check(updCount == 1, "R10", "second closed tick ends interval", updCount, 1);

    summary();
    $finish;
  end

endmodule